// File: doc/BRIEF.md
# Bit-Slip Receive Word Aligner

This block sits in a receive datapath right after a deserializer. It takes one raw parallel word per clock and re-frames the serial stream so that the boundaries of the output words can be moved one bit at a time. It keeps the previous raw word and the current one side by side as a double-width window. It picks a word-wide slice of that window at a bit offset that wraps at the word width.

A two-bit mode input selects how the offset moves. In the disabled mode the slide input has no effect, and a built-in comma aligner sets the offset. In the two manual modes each accepted pulse on the slide input moves the offset one bit, to the left or to the right. The pulse overrides the comma aligner while it is high. In the automatic mode the block slips on its own until the comma sits at the bottom of the output word, and waits a programmable number of cycles between slips.

A slide pulse that comes too soon after the previous one is dropped, and a sticky error flag records it. An aligned flag travels with every output word.

Top module: `bitslip_aligner`

## Requirements
- R1: After reset the offset is 0, and `word_o`, `aligned_o` and `slide_err_o` are 0. `word_o` is registered one cycle after `raw_i`. At offset k it equals bits [2W-1-k : W-k] of the window {raw_i, previous raw_i}. At offset 0 it is therefore `raw_i` delayed by one cycle.
- R2: In mode 1 (left), an accepted slide request raises the offset by one, and 19 wraps to 0. The output word shifts left one bit, and its new low bit is the top bit of the previous raw word. The new offset applies from the second output word after the request cycle.
- R3: In mode 2 (right), an accepted slide request lowers the offset by one, and 0 wraps to 19.
- R4: Only a rising edge of `slide_i` is a request. Holding `slide_i` high for further cycles never moves the offset again.
- R5: A rising edge is accepted only if `slide_i` was low in at least the five cycles just before it. The first request after reset is accepted.
- R6: In a manual mode, a rising edge that comes too early is dropped: the offset does not move. `slide_err_o` goes to 1 on the next edge and stays 1 until reset.
- R7: In a manual mode, while `slide_i` is high the comma aligner never changes the offset.
- R8: In modes 0, 1 and 2 with `slide_i` low, the comma aligner acts when the current offset does not put the comma at the bottom of the output word. It moves the offset to the lowest offset k whose slice has the comma in bits [9:0], effective for the next word. The comma is 10'b0101111100.
- R9: In mode 0 (disabled), `slide_i` neither moves the offset nor sets `slide_err_o`.
- R10: In mode 3 (automatic), `slide_i` is ignored. While the comma is not at the current offset, a wait counter that is 0 causes a slip (offset + 1) and is reloaded from `wait_i`; otherwise the counter counts down. No slip happens while the comma is at the current offset.
- R11: `aligned_o` is 1 exactly when bits [9:0] of `word_o` equal the comma.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_i | input | 20 | Raw word from the deserializer |
| mode_i | input | 2 | 0 disabled, 1 left slip, 2 right slip, 3 automatic |
| slide_i | input | 1 | Slide request, acts on its rising edge |
| wait_i | input | 4 | Cycles to wait after each automatic slip (0 to 15) |
| word_o | output | 20 | Re-framed output word |
| aligned_o | output | 1 | Comma present in bits [9:0] of word_o |
| slide_err_o | output | 1 | Sticky flag: a slide request arrived too early |

## Verification
In the manual modes the stream is random data masked to hold no run of five ones. The comma aligner can then never fire, so every move of the output can be traced to one slide pulse and its direction. Twenty-five pulses in each mode cross the wrap. Held pulses and gaps of exactly four and five low cycles separate the accepted requests from the rejected ones. A repeating word with the comma at a fixed stream position shows three things: that a held slide beats the comma aligner, that the aligner snaps to the lowest matching offset once released, and that automatic mode slips at the paced rate for wait settings of 5 and 0 while slide pulses are ignored.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_LEFT  = 2'd1,
        MODE_RIGHT = 2'd2,
        MODE_AUTO  = 2'd3
    } bsa_mode_e;
endpackage

// File: rtl/bsa_slide_gate.sv
module bsa_slide_gate #(
    parameter int GAP = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slide_i,
    input  logic en_i,
    output logic req_o,
    output logic err_o
);
    localparam int LW = $clog2(GAP + 2);
    localparam logic [LW-1:0] LOW_SAT = LW'(GAP + 1);

    typedef struct packed {
        logic          sl;
        logic [LW-1:0] low;
        logic          err;
    } gate_s;

    gate_s r_q, r_d;
    logic  rise;
    logic  gap_ok;

    assign rise   = slide_i && !r_q.sl;
    assign gap_ok = (r_q.low == LOW_SAT);
    assign req_o  = en_i && rise && gap_ok;
    assign err_o  = r_q.err;

    always_comb begin
        r_d    = r_q;
        r_d.sl = slide_i;
        if (slide_i) begin
            r_d.low = '0;
        end else if (r_q.low != LOW_SAT) begin
            r_d.low = r_q.low + 1'b1;
        end
        if (en_i && rise && !gap_ok) begin
            r_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.sl  <= 1'b0;
            r_q.low <= LOW_SAT;
            r_q.err <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o); // R6
    AST_EARLY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && slide_i && !r_q.sl && r_q.low <= LW'(GAP)) |-> (!req_o ##1 err_o)); // R5
    AST_HELD_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (slide_i && $past(slide_i)) |-> !req_o); // R4
endmodule

// File: rtl/bsa_comma_scan.sv
module bsa_comma_scan #(
    parameter int          W     = 20,
    parameter int          CW    = 10,
    parameter logic [CW-1:0] COMMA = 10'b0101111100,
    localparam int         OW    = $clog2(W)
) (
    input  logic [2*W-1:0] wdw_i,
    input  logic [OW-1:0]  off_i,
    output logic           hit_cur_o,
    output logic           hit_any_o,
    output logic [OW-1:0]  hit_off_o
);
    logic [W-1:0] hits;

    for (genvar k = 0; k < W; k++) begin : g_pos
        assign hits[k] = (wdw_i[W-k+CW-1 : W-k] == COMMA);
    end

    assign hit_cur_o = hits[off_i];
    assign hit_any_o = |hits;

    always_comb begin
        hit_off_o = '0;
        for (int k = W - 1; k >= 0; k--) begin
            if (hits[k]) begin
                hit_off_o = OW'(k);
            end
        end
    end
endmodule

// File: rtl/bitslip_aligner.sv
module bitslip_aligner
    import bsa_pkg::*;
#(
    parameter int            W      = 20,
    parameter int            CW     = 10,
    parameter logic [CW-1:0] COMMA  = 10'b0101111100,
    parameter int            GAP    = 4,
    parameter int            WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      raw_i,
    input  logic [1:0]        mode_i,
    input  logic              slide_i,
    input  logic [WAIT_W-1:0] wait_i,
    output logic [W-1:0]      word_o,
    output logic              aligned_o,
    output logic              slide_err_o
);
    localparam int OW = $clog2(W);
    localparam int SW = $clog2(2 * W + 1);

    typedef struct packed {
        logic [W-1:0]      prev;
        logic [OW-1:0]     off;
        logic [WAIT_W-1:0] wcnt;
        logic [W-1:0]      word;
        logic              aligned;
    } top_s;

    function automatic logic [OW-1:0] off_inc(input logic [OW-1:0] o);
        return (o == OW'(W - 1)) ? '0 : o + 1'b1;
    endfunction

    function automatic logic [OW-1:0] off_dec(input logic [OW-1:0] o);
        return (o == '0) ? OW'(W - 1) : o - 1'b1;
    endfunction

    top_s          r_q, r_d;
    bsa_mode_e     mode;
    logic [2*W-1:0] win;
    logic [SW-1:0] shamt;
    logic          manual;
    logic          req;
    logic          hit_cur, hit_any;
    logic [OW-1:0] hit_off;

    assign mode   = bsa_mode_e'(mode_i);
    assign win    = {raw_i, r_q.prev};
    assign shamt  = SW'(W) - SW'(r_q.off);
    assign manual = (mode == MODE_LEFT) || (mode == MODE_RIGHT);

    bsa_slide_gate #(.GAP(GAP)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .slide_i (slide_i),
        .en_i    (manual),
        .req_o   (req),
        .err_o   (slide_err_o)
    );

    bsa_comma_scan #(.W(W), .CW(CW), .COMMA(COMMA)) u_scan (
        .wdw_i     (win),
        .off_i     (r_q.off),
        .hit_cur_o (hit_cur),
        .hit_any_o (hit_any),
        .hit_off_o (hit_off)
    );

    always_comb begin
        r_d         = r_q;
        r_d.prev    = raw_i;
        r_d.word    = W'(win >> shamt);
        r_d.aligned = (r_d.word[CW-1:0] == COMMA);
        unique case (mode)
            MODE_OFF: begin
                if (!hit_cur && hit_any) r_d.off = hit_off;
            end
            MODE_LEFT, MODE_RIGHT: begin
                if (req) begin
                    r_d.off = (mode == MODE_LEFT) ? off_inc(r_q.off) : off_dec(r_q.off);
                end else if (!slide_i && !hit_cur && hit_any) begin
                    r_d.off = hit_off;
                end
            end
            MODE_AUTO: begin
                if (!hit_cur) begin
                    if (r_q.wcnt == '0) begin
                        r_d.off  = off_inc(r_q.off);
                        r_d.wcnt = wait_i;
                    end else begin
                        r_d.wcnt = r_q.wcnt - 1'b1;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign word_o    = r_q.word;
    assign aligned_o = r_q.aligned;

    AST_OFF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.off < OW'(W)); // R1
    AST_LEFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_LEFT && req) |=> r_q.off == off_inc($past(r_q.off))); // R2
    AST_RIGHT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RIGHT && req) |=> r_q.off == off_dec($past(r_q.off))); // R3
    AST_SLIDE_PRECEDENCE: assert property (@(posedge clk) disable iff (!rst_n)
        (manual && slide_i && !req) |=> $stable(r_q.off)); // R7
    AST_OFF_MODE_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OFF && !hit_any) |=> $stable(r_q.off)); // R9
    AST_AUTO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_AUTO && (hit_cur || r_q.wcnt != '0)) |=> $stable(r_q.off)); // R10
    AST_ALIGNED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        aligned_o == (word_o[CW-1:0] == COMMA)); // R11
endmodule

// File: tb/sim_bitslip_aligner.sv
module sim_bitslip_aligner;
    localparam logic [9:0]  COMMA = 10'b0101111100;
    localparam logic [19:0] SAFE  = 20'hDB6DB;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] raw_i = '0;
    logic [1:0]  mode_i = 2'd0;
    logic        slide_i = 1'b0;
    logic [3:0]  wait_i = 4'd5;
    logic [19:0] word_o;
    logic        aligned_o;
    logic        slide_err_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    bitslip_aligner u0 (
        .clk(clk), .rst_n(rst_n), .raw_i(raw_i), .mode_i(mode_i),
        .slide_i(slide_i), .wait_i(wait_i), .word_o(word_o),
        .aligned_o(aligned_o), .slide_err_o(slide_err_o)
    );

    always #5 clk = ~clk;

    // reference state kept from the requirements
    logic [19:0] m_prev = '0;
    int          m_off  = 0;
    int          m_low  = 5;
    logic        m_sl   = 1'b0;
    logic        m_err  = 1'b0;
    int          m_wcnt = 0;

    logic [19:0] q_word[$];
    logic        q_al[$];
    logic        q_err[$];
    string       q_tag[$];

    task automatic check(input string tag, input logic [19:0] act, input logic [19:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [19:0] slice(input logic [39:0] w, input int k);
        return 20'(w >> (20 - k));
    endfunction

    function automatic logic hit(input logic [39:0] w, input int k);
        logic [19:0] s = slice(w, k);
        return s[9:0] == COMMA;
    endfunction

    task automatic step(input logic [19:0] raw, input logic sl, input string tag);
        logic [39:0] w;
        logic [19:0] ew;
        logic        rise, req, any;
        int          first;
        @(negedge clk);
        raw_i   = raw;
        slide_i = sl;
        w    = {raw, m_prev};
        ew   = slice(w, m_off);
        rise = sl && !m_sl;
        any  = 1'b0;
        first = 0;
        for (int k = 19; k >= 0; k--) if (hit(w, k)) begin any = 1'b1; first = k; end
        req = (mode_i == 2'd1 || mode_i == 2'd2) && rise && (m_low > 4);
        if ((mode_i == 2'd1 || mode_i == 2'd2) && rise && !(m_low > 4)) m_err = 1'b1;
        case (mode_i)
            2'd0: if (!hit(w, m_off) && any) m_off = first;
            2'd1, 2'd2: begin
                if (req) m_off = (mode_i == 2'd1) ? (m_off + 1) % 20 : (m_off + 19) % 20;
                else if (!sl && !hit(w, m_off) && any) m_off = first;
            end
            default: begin
                if (!hit(w, m_off)) begin
                    if (m_wcnt == 0) begin m_off = (m_off + 1) % 20; m_wcnt = wait_i; end
                    else m_wcnt = m_wcnt - 1;
                end
            end
        endcase
        m_low  = sl ? 0 : ((m_low < 5) ? m_low + 1 : 5);
        m_sl   = sl;
        m_prev = raw;
        q_word.push_back(ew);
        q_al.push_back(ew[9:0] == COMMA);
        q_err.push_back(m_err);
        q_tag.push_back(tag);
    endtask

    // monitor: compares each produced word against the queued expectation
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q_word.size() > 0) begin
                string t;
                logic [19:0] ew;
                logic ea, ee;
                t  = q_tag.pop_front();
                ew = q_word.pop_front();
                ea = q_al.pop_front();
                ee = q_err.pop_front();
                check({t, " word"}, word_o, ew);
                check("R11 aligned", {19'd0, aligned_o}, {19'd0, ea});
                check("R6 err flag", {19'd0, slide_err_o}, {19'd0, ee});
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                fails++;
                $display("FAIL watchdog actual=%0d expected<150000", cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    task automatic pulse(input int low_after, input string tag);
        step($urandom & SAFE, 1'b1, tag);
        for (int i = 0; i < low_after; i++) step($urandom & SAFE, 1'b0, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset word", word_o, 20'd0);
        check("R1 reset aligned", {19'd0, aligned_o}, 20'd0);
        check("R1 reset err", {19'd0, slide_err_o}, 20'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // disabled mode: plain one-cycle pass-through, slide unused
        mode_i = 2'd0;
        for (int i = 0; i < 8; i++) step($urandom & SAFE, 1'b0, "R1 passthrough");
        for (int i = 0; i < 4; i++) pulse(1, "R9 slide in disabled");
        for (int i = 0; i < 6; i++) step($urandom & SAFE, 1'b0, "R9 settle");

        // left slipping across the wrap
        mode_i = 2'd1;
        for (int i = 0; i < 25; i++) pulse(5, "R2 left slip");
        step($urandom & SAFE, 1'b1, "R4 held");
        for (int i = 0; i < 6; i++) step($urandom & SAFE, 1'b1, "R4 held");
        for (int i = 0; i < 5; i++) step($urandom & SAFE, 1'b0, "R4 release");

        // right slipping across the wrap
        mode_i = 2'd2;
        for (int i = 0; i < 25; i++) pulse(5, "R3 right slip");

        // gap rule: four low cycles too few, five enough
        pulse(4, "R5 first");
        pulse(5, "R6 early rejected");
        pulse(5, "R5 accepted after five");
        pulse(5, "R5 accepted again");

        // slide held over a comma stream, then released
        mode_i = 2'd1;
        for (int i = 0; i < 4; i++) step(20'(COMMA) << 7, 1'b1, "R7 precedence");
        for (int i = 0; i < 8; i++) step(20'(COMMA) << 7, 1'b0, "R8 snap after release");
        #1 check("R8 locked", {19'd0, aligned_o}, 20'd1);

        // disabled mode comma aligner follows a moved comma
        mode_i = 2'd0;
        for (int i = 0; i < 8; i++) step(20'(COMMA) << 3, 1'b0, "R8 realign");
        #1 check("R8 relocked", {19'd0, aligned_o}, 20'd1);

        // automatic mode, paced slips, slide ignored
        mode_i = 2'd3;
        wait_i = 4'd5;
        for (int i = 0; i < 200; i++) step(20'(COMMA) << 11, 1'($urandom), "R10 auto wait5");
        #1 check("R10 auto lock", {19'd0, aligned_o}, 20'd1);
        wait_i = 4'd0;
        for (int i = 0; i < 60; i++) step(20'(COMMA) << 5, 1'($urandom), "R10 auto wait0");
        #1 check("R10 auto relock", {19'd0, aligned_o}, 20'd1);

        step($urandom & SAFE, 1'b0, "R10 tail");
        repeat (3) @(posedge clk);
        #3;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule